// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol engine that lets a byte-wide storage array answer as a slave on a two-wire serial bus. It runs on a fast system clock. It passes the raw clock and data lines through synchronizers and finds the bus events on the synchronized copies. It pulls the data line low through an open-drain enable. A transfer opens with a START condition and a select byte. The select byte carries a fixed family code, the strap value of the device and a direction bit. When the select byte names this device, the engine acknowledges it and runs the transfer that was asked for.

Writes load a word pointer from the first byte after the select byte. Every later byte is committed to the memory port through a one-cycle write strobe, and the pointer then steps inside its page. Reads stream bytes from the pointer and advance it across the whole address range. The stream goes on for as long as the host acknowledges each byte. A STOP that ends a write containing data starts a programming interval of fixed length. During that interval the engine acknowledges no select byte, so the host can poll until the device answers.

Top module: `tws_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe` is 0 and `mem_wr` is 0.
- R2: A START (SDA falls while SCL is high) is required before any byte is accepted. Bytes clocked without a START get no acknowledge. A STOP (SDA rises while SCL is high) returns the engine to idle from any state.
- R3: A select byte is accepted only if bits 7:4 are 1010 and bits 3:1 equal `hw_addr`. Bit 0 set to 1 selects a read, and 0 selects a write. Any other select byte gets no acknowledge and no further response.
- R4: Each accepted byte is acknowledged by holding SDA low for the whole ninth SCL clock. The line is released when that clock falls.
- R5: In a write, the byte after the select byte loads the word pointer. Each later byte produces exactly one `mem_wr` pulse, with `mem_addr` at the pointer and `mem_wdata` at the byte.
- R6: During writes the pointer increments only in its low PAGE_W bits (3 by default, giving 8-byte pages). The higher bits stay fixed, so a long page write wraps to the start of the page.
- R7: A STOP that ends a write carrying at least one data byte starts a busy interval of BUSY_CYCLES system clocks. During that interval no select byte is acknowledged, including a write-select poll. After it ends, select bytes are acknowledged again.
- R8: A random read is a write-select and a word address, then a repeated START and a read-select. It returns the byte stored at the address just loaded.
- R9: A read-select with no address phase returns the byte at the current pointer, which is one past the last byte accessed.
- R10: A host acknowledge after a read byte requests the next byte. The pointer advances over the full address range and wraps from the top address to 0. A host no-acknowledge ends the transfer, and the engine stops driving SDA.
- R11: Read data leaves MSB first. `sda_oe` changes only while SCL is low.
- R12: A START seen in any state, even in the middle of a byte, restarts reception of a select byte. A partly received data byte is discarded without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line, as seen on the wire |
| hw_addr | input | 3 | Strapped device number compared with select bits 3:1 |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_addr | output | ADDR_W | Memory address: the write address while `mem_wr` is high, otherwise the read pointer |
| mem_wdata | output | 8 | Byte to store |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |

## Verification
The assertions assume a well-behaved host. SDA moves only while SCL is low, except at START and STOP. Each SCL level lasts several system clocks. The slave is never driving when a START or STOP is issued. The bench host meets these conditions by construction. It changes SDA in the middle of each low phase, holds every SCL level for ten system clocks, and issues its mid-byte START only while the slave is receiving. The memory sits in the bench as a combinational read array. A separate reference memory and pointer model decide every expected acknowledge, data byte and write strobe.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [3:0] SEL_FAMILY = 4'b1010;
    localparam int         DEV_BITS   = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tws_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic [3:0]          family;
        logic [DEV_BITS-1:0] dev;
        logic                rd;
    } sel_byte_t;

    function automatic logic sel_hit(sel_byte_t s, logic [DEV_BITS-1:0] hw);
        return (s.family == SEL_FAMILY) && (s.dev == hw);
    endfunction

    function automatic logic is_rx_state(tws_state_e s);
        return (s == ST_SEL) || (s == ST_WADDR) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_raw};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_raw};
            scl_d  <= scl_ff[LAST];
            sda_d  <= sda_ff[LAST];
        end
    end

    always_comb begin
        evt.scl      = scl_ff[LAST];
        evt.sda      = sda_ff[LAST];
        evt.scl_rise = scl_ff[LAST] & ~scl_d;
        evt.scl_fall = ~scl_ff[LAST] & scl_d;
        evt.start    = scl_ff[LAST] & scl_d & sda_d & ~sda_ff[LAST];
        evt.stop     = scl_ff[LAST] & scl_d & ~sda_d & sda_ff[LAST];
    end

endmodule

// File: rtl/tws_word_ptr.sv
module tws_word_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] nxt_full;
    logic [ADDR_W-1:0] nxt_page;

    assign nxt_full = ptr + 1'b1;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign nxt_page = nxt_full;
        end else begin : g_paged
            logic [PAGE_W-1:0] low_inc;
            assign low_inc  = ptr[PAGE_W-1:0] + 1'b1;
            assign nxt_page = {ptr[ADDR_W-1:PAGE_W], low_inc};

            // R6: a page step never disturbs the upper pointer bits
            assert_page_upper_R6: assert property (@(posedge clk) disable iff (rst)
                (inc_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)           ptr <= '0;
        else if (load)     ptr <= load_val;
        else if (inc_page) ptr <= nxt_page;
        else if (inc_full) ptr <= nxt_full;
    end

endmodule

// File: rtl/tws_busy_timer.sv
module tws_busy_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (go)         cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: a programming request always opens a busy window
    assert_busy_opens_R7: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int BUSY_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [DEV_BITS-1:0] hw_addr,
    output logic                sda_oe,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                mem_wr,
    input  logic [7:0]          mem_rdata
);

    localparam logic [3:0] LAST_BIT = 4'd8;

    bus_evt_t          evt;
    tws_state_e        state;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic              rd_q;
    logic              mack;
    logic              wr_pend;
    logic              busy;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] wr_addr;
    logic              byte_done;
    logic              ptr_load;
    logic              ptr_inc_page;
    logic              ptr_inc_full;
    logic              busy_go;
    sel_byte_t         sel_view;

    tws_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    always_comb begin
        sel_view     = sel_byte_t'(shreg);
        byte_done    = evt.scl_fall && (bitcnt == LAST_BIT);
        ptr_load     = (state == ST_WADDR) && byte_done;
        ptr_inc_page = (state == ST_WDATA) && byte_done;
        ptr_inc_full = (state == ST_RDATA) && byte_done;
        busy_go      = evt.stop && wr_pend;
    end

    tws_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (shreg[ADDR_W-1:0]),
        .inc_page (ptr_inc_page),
        .inc_full (ptr_inc_full),
        .ptr      (ptr)
    );

    tws_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .go   (busy_go),
        .busy (busy)
    );

    assign mem_addr = mem_wr ? wr_addr : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            sda_oe    <= 1'b0;
            rd_q      <= 1'b0;
            mack      <= 1'b0;
            wr_pend   <= 1'b0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
            wr_addr   <= '0;
        end else begin
            mem_wr <= 1'b0;
            if (evt.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                bitcnt  <= '0;
                wr_pend <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_SEL;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else begin
                if (evt.scl_rise) begin
                    if (is_rx_state(state))
                        shreg <= {shreg[6:0], evt.sda};
                    if (state == ST_RACK)
                        mack <= ~evt.sda;
                    if ((is_rx_state(state) || state == ST_RDATA) && bitcnt != LAST_BIT)
                        bitcnt <= bitcnt + 1'b1;
                end
                if (evt.scl_fall) begin
                    unique case (state)
                        ST_SEL: if (byte_done) begin
                            bitcnt <= '0;
                            if (sel_hit(sel_view, hw_addr) && !busy) begin
                                sda_oe <= 1'b1;
                                rd_q   <= sel_view.rd;
                                state  <= ST_SEL_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_SEL_ACK: begin
                            if (rd_q) begin
                                txreg  <= mem_rdata;
                                sda_oe <= ~mem_rdata[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WADDR;
                            end
                        end
                        ST_WADDR: if (byte_done) begin
                            bitcnt <= '0;
                            sda_oe <= 1'b1;
                            state  <= ST_WADDR_ACK;
                        end
                        ST_WADDR_ACK: begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                        ST_WDATA: if (byte_done) begin
                            bitcnt    <= '0;
                            sda_oe    <= 1'b1;
                            mem_wr    <= 1'b1;
                            mem_wdata <= shreg;
                            wr_addr   <= ptr;
                            wr_pend   <= 1'b1;
                            state     <= ST_WDATA_ACK;
                        end
                        ST_WDATA_ACK: begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                        ST_RDATA: begin
                            if (byte_done) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                            end
                        end
                        ST_RACK: begin
                            if (mack) begin
                                txreg  <= mem_rdata;
                                sda_oe <= ~mem_rdata[7];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1: the engine drives nothing while it is held in reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !mem_wr));

    // R2: a STOP always lands in idle
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE));

    // R12: a START always restarts select reception from bit zero
    assert_start_restart_R12: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_SEL && bitcnt == '0));

    // R3, R4: the select acknowledge follows a full byte carrying the right code
    assert_sel_match_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEL_ACK && $past(state) == ST_SEL) |->
        ($past(shreg[7:4]) == SEL_FAMILY && $past(shreg[3:1]) == hw_addr && $past(bitcnt) == LAST_BIT));

    // R7: no select acknowledge while programming is in progress
    assert_busy_noack_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEL_ACK && $past(state) == ST_SEL) |-> !$past(busy));

    // R5: each write strobe lasts exactly one cycle
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R11: the line enable moves only while the synchronized clock is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !evt.scl);

endmodule

// File: tb/tws_slave_bench.sv
module tws_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int QTR        = 5;
    localparam logic [2:0] HW = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, HW, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, HW, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_wr;
    logic [7:0] mem_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [256];
    int         ref_mem [256];
    int         ref_ptr = 0;
    int         exp_wr [$];
    int         n_tests = 0;
    int         n_fail = 0;
    int         oe_viol = 0;
    bit         oe_prev = 1'b0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    tws_slave u_tws_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .hw_addr   (HW),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i ^ 8'hC3);
            oe_prev = 1'b0;
        end else begin
            if (sda_oe !== oe_prev && scl_m) oe_viol++;
            oe_prev = sda_oe;
            if (mem_wr) begin
                mem[mem_addr] <= mem_wdata;
                if (exp_wr.size() == 0) begin
                    chk("R5 unexpected write", {mem_addr, mem_wdata}, -1);
                end else begin
                    chk("R5 write addr/data", {mem_addr, mem_wdata}, exp_wr.pop_front());
                end
            end
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(QTR);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b0; hold(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(QTR);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b1; hold(HALF);
    endtask

    task automatic put_bit(bit b);
        sda_m = b;    hold(QTR);
        scl_m = 1'b1; hold(HALF);
        scl_m = 1'b0; hold(QTR);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; hold(QTR);
        scl_m = 1'b1; hold(QTR);
        b = sda_line; hold(QTR);
        scl_m = 1'b0; hold(QTR);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!host_ack);
    endtask

    task automatic do_write(int addr, int first, int count);
        bit ok;
        bus_start();
        send_byte(SEL_W, ok);  chk("R4 write select ack", ok, 1);
        send_byte(8'(addr), ok); chk("R5 address ack", ok, 1);
        ref_ptr = addr;
        for (int k = 0; k < count; k++) begin
            int d = (first + k * 8'h11) & 8'hFF;
            exp_wr.push_back((ref_ptr << 8) | d);
            ref_mem[ref_ptr] = d;
            ref_ptr = (ref_ptr & 8'hF8) | ((ref_ptr + 1) & 7);
            send_byte(8'(d), ok); chk("R4 data ack", ok, 1);
        end
        bus_stop();
    endtask

    task automatic poll_ready();
        bit ok;
        bit first_ok = 1'b0;
        int polls = 0;
        ok = 1'b0;
        while (!ok && polls < 20) begin
            bus_start();
            send_byte(SEL_W, ok);
            if (polls == 0) first_ok = ok;
            bus_stop();
            polls++;
        end
        chk("R7 first poll not acknowledged", first_ok, 0);
        chk("R7 acknowledge after busy ends", ok, 1);
    endtask

    task automatic read_stream(int n, string req);
        logic [7:0] v;
        bit b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, v);
            chk(req, v, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) & 8'hFF;
        end
        get_bit(b);
        chk("R10 line released after host nak", b, 1);
        bus_stop();
    endtask

    task automatic rand_read(int addr, int n, string req);
        bit ok;
        bus_start();
        send_byte(SEL_W, ok);    chk("R8 dummy write select ack", ok, 1);
        send_byte(8'(addr), ok); chk("R8 address ack", ok, 1);
        ref_ptr = addr;
        bus_start();
        send_byte(SEL_R, ok);    chk("R8 read select ack", ok, 1);
        read_stream(n, req);
    endtask

    task automatic cur_read(int n, string req);
        bit ok;
        bus_start();
        send_byte(SEL_R, ok); chk("R9 read select ack", ok, 1);
        read_stream(n, req);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            report();
        end
    end

    initial begin
        bit ok;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) ref_mem[i] = i ^ 8'hC3;
        hold(6);
        rst = 1'b0;
        hold(2);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 mem_wr after reset", mem_wr, 0);

        // R2: bytes without a START are ignored
        scl_m = 1'b0; hold(HALF);
        send_byte(SEL_W, ok); chk("R2 no ack without START", ok, 0);
        bus_stop();
        // R2: a STOP drops an active transfer back to idle
        bus_start();
        send_byte(SEL_W, ok); chk("R2 select ack before STOP", ok, 1);
        bus_stop();
        scl_m = 1'b0; hold(HALF);
        send_byte(SEL_W, ok); chk("R2 no ack after STOP without START", ok, 0);
        bus_stop();

        // R3: wrong device number and wrong family code
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ok); chk("R3 wrong device number", ok, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, HW, 1'b0}, ok); chk("R3 wrong family code", ok, 0);
        bus_stop();

        // R5, R7: single byte write, then polling
        do_write(8'h10, 8'h5A, 1);
        poll_ready();

        // R8, R10: random read continuing sequentially
        rand_read(8'h10, 3, "R8 random/sequential read data");
        // R9: current-address read continues from the pointer
        cur_read(1, "R9 current address read data");

        // R6: page write wrapping inside an 8-byte page
        do_write(8'h3C, 8'h21, 6);
        poll_ready();
        cur_read(1, "R6 pointer after page wrap");
        chk("R6 wrapped byte at page start", mem[8'h38], ref_mem[8'h38]);
        chk("R6 next page untouched", mem[8'h40], ref_mem[8'h40]);

        // R10: sequential read across the top address
        rand_read(8'hFE, 4, "R10 read wrap across top");

        // R12: START in the middle of a data byte
        bus_start();
        send_byte(SEL_W, ok); chk("R12 select ack", ok, 1);
        send_byte(8'h20, ok); chk("R12 address ack", ok, 1);
        ref_ptr = 8'h20;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(SEL_R, ok); chk("R12 select after mid-byte START", ok, 1);
        recv_byte(1'b0, v);
        chk("R12 read from loaded address", v, ref_mem[8'h20]);
        bus_stop();

        hold(4 * HALF);
        chk("R5 pending writes consumed", exp_wr.size(), 0);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== 8'(ref_mem[i])) bad++;
            chk("R5 memory matches reference", bad, 0);
        end
        chk("R11 sda_oe changed only with SCL low", oe_viol, 0);
        done = 1'b1;
        report();
    end

endmodule